// File: doc/BRIEF.md
# Memory-Swept Spiking Neuron Core

This block is a single digital spiking neuron. It holds a signed membrane potential and updates it once per time slice. A one-cycle pulse on the step input opens a slice and captures the spike input vector. An address counter then walks a small shared memory. For every captured input that carries a spike, the weight stored for that input is added to the potential, and the sum saturates at the signed range limits.

After the weights, one more memory entry is read. This entry is a slope magnitude, and it moves the potential toward a configurable resting value. The step never goes past the resting value. If the potential has reached the threshold when the slope phase comes, the neuron does not apply the slope. It emits a one-clock output spike, loads the after-spike value and enters the refractory phase.

In the refractory phase the potential climbs back to rest using a separate rise slope, and the neuron returns to the operational phase when the potential equals rest. While the neuron is refractory, input spikes are either ignored or have their weights attenuated by an arithmetic right shift, depending on a mode input. The same memory write port loads the weights and both slopes.

Top module: `spk_neuron_core`

## Requirements
- R1: After a synchronous reset, the potential is zero, the phase is operational (`refr_o` = 0), and `spike_o` and `busy_o` are low.
- R2: A step pulse accepted while idle captures `spk_i` on that edge. `busy_o` is then high for exactly N_IN+2 cycles, and the results appear in the cycle in which `busy_o` falls. Changes to `spk_i` after the capturing edge have no effect on that slice.
- R3: A step pulse that arrives while `busy_o` is high is ignored. The current slice ends at its normal time and no new slice starts.
- R4: Memory entries 0 to N_IN-1 hold the signed weights of inputs 0 to N_IN-1. In the operational phase, the weight of every captured input that carries a spike is added to the potential.
- R5: In the operational phase, when no firing occurs, the potential moves toward the rest value by the unsigned magnitude held in entry N_IN+1. A step that would pass the rest value stops exactly at the rest value.
- R6: If the potential after the weight phase is greater than or equal to the threshold, and the neuron is operational, `spike_o` is asserted, the potential becomes the after-spike value, and `refr_o` becomes 1. The slope is not applied in that slice.
- R7: In the refractory phase, the potential moves toward rest by the magnitude held in entry N_IN, with the same clamp. The neuron returns to the operational phase in the slice where the potential equals rest.
- R8: In the refractory phase with `refr_abs_i` = 1, input spikes do not change the potential.
- R9: In the refractory phase with `refr_abs_i` = 0, each spiking weight is arithmetically shifted right by `att_sh_i` before it is added.
- R10: Each weight addition saturates at the most positive and most negative values of the P_W-bit potential instead of wrapping.
- R11: `spike_o` is high for one clock cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One-cycle pulse that opens a time slice |
| spk_i | input | N_IN | Input spike vector, captured on the step pulse |
| wr_en_i | input | 1 | Write strobe for the weight/slope memory |
| wr_addr_i | input | AW | Memory entry to write |
| wr_data_i | input | W | Signed weight or unsigned slope magnitude |
| rest_i | input | P_W | Signed resting potential |
| thr_i | input | P_W | Signed firing threshold |
| aft_i | input | P_W | Signed after-spike potential |
| refr_abs_i | input | 1 | 1: refractory ignores inputs; 0: attenuates them |
| att_sh_i | input | SH_W | Right-shift amount used for refractory attenuation |
| spike_o | output | 1 | Output spike pulse |
| busy_o | output | 1 | High while a slice is being computed |
| refr_o | output | 1 | High in the refractory phase |
| pot_o | output | P_W | Signed membrane potential |

## Verification
The potential and the phase carry over from one slice to the next. A wrong weight address, a wrong slope selection or a missed clamp therefore shows on `pot_o` at the end of the slice in which it happens. It also changes the firing slice of every later slice. A sweep-counter fault shows at once as a wrong `busy_o` length. A phase fault shows as early or late output spikes within one or two slices. Every slice is compared against an arithmetic model, across all input patterns and all refractory modes, so most faults are seen in the first slice that uses the faulty path.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic {
    PH_OPER = 1'b0,
    PH_REFR = 1'b1
  } nrn_phase_e;
endpackage

// File: rtl/spk_wmem.sv
module spk_wmem #(
  parameter int W  = 9,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] mem [DEPTH];

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/spk_sweep.sv
module spk_sweep #(
  parameter int N_IN = 14,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic [N_IN-1:0] spk_i,
  input  logic            refr_i,
  output logic [AW-1:0]   raddr_o,
  output logic            v_o,
  output logic            last_o,
  output logic            hit_o,
  output logic            busy_o
);
  localparam logic [AW-1:0] SL_RISE = AW'(N_IN);
  localparam logic [AW-1:0] SL_FALL = AW'(N_IN + 1);

  logic            run;
  logic [AW-1:0]   cnt;
  logic [N_IN-1:0] spk_q;
  logic [N_IN-1:0] sel;

  assign sel     = spk_q >> cnt;
  assign raddr_o = (cnt == SL_RISE) ? (refr_i ? SL_RISE : SL_FALL) : cnt;
  assign busy_o  = run | v_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      spk_q  <= '0;
      v_o    <= 1'b0;
      last_o <= 1'b0;
      hit_o  <= 1'b0;
    end else begin
      v_o    <= run;
      last_o <= run && (cnt == SL_RISE);
      hit_o  <= run && (cnt != SL_RISE) && sel[0];
      if (step_i && !busy_o) begin
        run   <= 1'b1;
        cnt   <= '0;
        spk_q <= spk_i;
      end else if (run) begin
        if (cnt == SL_RISE) run <= 1'b0;
        else                cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spk_membrane.sv
module spk_membrane
  import spk_pkg::*;
#(
  parameter int W    = 9,
  parameter int P_W  = 12,
  parameter int SH_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_i,
  input  logic                  last_i,
  input  logic                  hit_i,
  input  logic signed [W-1:0]   mem_i,
  input  logic signed [P_W-1:0] rest_i,
  input  logic signed [P_W-1:0] thr_i,
  input  logic signed [P_W-1:0] aft_i,
  input  logic                  refr_abs_i,
  input  logic [SH_W-1:0]       att_sh_i,
  output logic signed [P_W-1:0] pot_o,
  output logic                  refr_o,
  output logic                  spike_o
);
  localparam int E = ((P_W > W) ? P_W : W) + 2;
  localparam logic signed [E-1:0] PMAX = E'((2 ** (P_W - 1)) - 1);
  localparam logic signed [E-1:0] PMIN = -PMAX - E'(1);

  nrn_phase_e phase;
  logic signed [E-1:0] pot_x, rest_x, w_x, w_eff, sum, sat_v;
  logic signed [E-1:0] mag, dn, up, toward;
  logic                take;

  assign refr_o = (phase == PH_REFR);

  always_comb begin
    pot_x  = E'(pot_o);
    rest_x = E'(rest_i);
    w_x    = E'(mem_i);
    w_eff  = refr_o ? (w_x >>> att_sh_i) : w_x;
    sum    = pot_x + w_eff;
    if (sum > PMAX)      sat_v = PMAX;
    else if (sum < PMIN) sat_v = PMIN;
    else                 sat_v = sum;
    mag = signed'({{(E - W){1'b0}}, mem_i});
    dn  = pot_x - mag;
    up  = pot_x + mag;
    if (pot_x > rest_x)      toward = (dn < rest_x) ? rest_x : dn;
    else if (pot_x < rest_x) toward = (up > rest_x) ? rest_x : up;
    else                     toward = rest_x;
    take = hit_i && (!refr_o || !refr_abs_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pot_o   <= '0;
      phase   <= PH_OPER;
      spike_o <= 1'b0;
    end else begin
      spike_o <= 1'b0;
      if (v_i && !last_i) begin
        if (take) pot_o <= P_W'(sat_v);
      end else if (v_i && last_i) begin
        if (!refr_o && (pot_o >= thr_i)) begin
          spike_o <= 1'b1;
          pot_o   <= aft_i;
          phase   <= PH_REFR;
        end else begin
          pot_o <= P_W'(toward);
          if (refr_o && (toward == rest_x)) phase <= PH_OPER;
        end
      end
    end
  end
endmodule

// File: rtl/spk_neuron_core.sv
module spk_neuron_core #(
  parameter int N_IN = 14,
  parameter int W    = 9,
  parameter int P_W  = 12,
  parameter int SH_W = 3,
  parameter int AW   = $clog2(N_IN + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_i,
  input  logic [N_IN-1:0]       spk_i,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic signed [W-1:0]   wr_data_i,
  input  logic signed [P_W-1:0] rest_i,
  input  logic signed [P_W-1:0] thr_i,
  input  logic signed [P_W-1:0] aft_i,
  input  logic                  refr_abs_i,
  input  logic [SH_W-1:0]       att_sh_i,
  output logic                  spike_o,
  output logic                  busy_o,
  output logic                  refr_o,
  output logic signed [P_W-1:0] pot_o
);
  logic [AW-1:0]       raddr;
  logic [W-1:0]        rdata;
  logic                v, last, hit;

  spk_sweep #(.N_IN(N_IN), .AW(AW)) u_sweep (
    .clk(clk), .rst(rst), .step_i(step_i), .spk_i(spk_i), .refr_i(refr_o),
    .raddr_o(raddr), .v_o(v), .last_o(last), .hit_o(hit), .busy_o(busy_o)
  );

  spk_wmem #(.W(W), .AW(AW)) u_mem (
    .clk(clk), .we_i(wr_en_i), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  spk_membrane #(.W(W), .P_W(P_W), .SH_W(SH_W)) u_mem_pot (
    .clk(clk), .rst(rst), .v_i(v), .last_i(last), .hit_i(hit),
    .mem_i(signed'(rdata)), .rest_i(rest_i), .thr_i(thr_i), .aft_i(aft_i),
    .refr_abs_i(refr_abs_i), .att_sh_i(att_sh_i),
    .pot_o(pot_o), .refr_o(refr_o), .spike_o(spike_o)
  );
endmodule

// File: rtl/spk_neuron_chk.sv
module spk_neuron_chk #(
  parameter int P_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  spike_o,
  input logic                  busy_o,
  input logic                  refr_o,
  input logic signed [P_W-1:0] pot_o,
  input logic signed [P_W-1:0] rest_i
);
  // R11: output spike lasts one cycle
  a_r11_spike_pulse: assert property (@(posedge clk) disable iff (rst)
    spike_o |=> !spike_o);

  // R6: a spike comes with entry into the refractory phase
  a_r6_fire_refr: assert property (@(posedge clk) disable iff (rst)
    spike_o |-> refr_o);

  // R2: a spike only appears as a slice finishes
  a_r2_spike_after_sweep: assert property (@(posedge clk) disable iff (rst)
    spike_o |-> (!busy_o && $past(busy_o)));

  // R3: the potential never moves without a sweep in progress
  a_r3_pot_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(busy_o) |-> $stable(pot_o));

  // R7: leaving the refractory phase happens at rest
  a_r7_exit_at_rest: assert property (@(posedge clk) disable iff (rst)
    $fell(refr_o) |-> (pot_o == rest_i));
endmodule

bind spk_neuron_core spk_neuron_chk #(.P_W(P_W)) u_chk (
  .clk(clk), .rst(rst), .spike_o(spike_o), .busy_o(busy_o),
  .refr_o(refr_o), .pot_o(pot_o), .rest_i(rest_i)
);

// File: tb/sim_spk_neuron_core.sv
module sim_spk_neuron_core;
  localparam int N_IN = 4;
  localparam int W    = 9;
  localparam int P_W  = 10;
  localparam int SH_W = 3;
  localparam int AW   = 3;
  localparam int PMAX = 511;
  localparam int PMIN = -512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 1'b0;
  logic [N_IN-1:0] spk_i = '0;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic signed [W-1:0] wr_data_i = '0;
  logic signed [P_W-1:0] rest_i, thr_i, aft_i;
  logic refr_abs_i = 1'b0;
  logic [SH_W-1:0] att_sh_i = 3'd1;
  logic spike_o, busy_o, refr_o;
  logic signed [P_W-1:0] pot_o;

  int nchk = 0, nbad = 0;
  bit done = 0;
  int wts [N_IN];
  int rise, fall, rest_v, thr_v, aft_v;
  int m_pot, m_refr, m_fire;

  always #5 clk = ~clk;

  spk_neuron_core #(.N_IN(N_IN), .W(W), .P_W(P_W), .SH_W(SH_W), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .spk_i(spk_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rest_i(rest_i), .thr_i(thr_i),
    .aft_i(aft_i), .refr_abs_i(refr_abs_i), .att_sh_i(att_sh_i),
    .spike_o(spike_o), .busy_o(busy_o), .refr_o(refr_o), .pot_o(pot_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = W'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic load_mem();
    for (int i = 0; i < N_IN; i++) wr(i, wts[i]);
    wr(N_IN, rise);
    wr(N_IN + 1, fall);
  endtask

  function automatic int clampsat(input int v);
    if (v > PMAX) return PMAX;
    if (v < PMIN) return PMIN;
    return v;
  endfunction

  task automatic model_slice(input logic [N_IN-1:0] pat);
    int p, mag;
    p = m_pot;
    for (int i = 0; i < N_IN; i++)
      if (pat[i]) begin
        if (m_refr == 0) p = clampsat(p + wts[i]);
        else if (!refr_abs_i) p = clampsat(p + (wts[i] >>> int'(att_sh_i)));
      end
    m_fire = 0;
    if (m_refr == 0 && p >= thr_v) begin
      m_fire = 1; p = aft_v; m_refr = 1;
    end else begin
      mag = (m_refr != 0) ? rise : fall;
      if (p > rest_v)      p = (p - mag < rest_v) ? rest_v : p - mag;
      else if (p < rest_v) p = (p + mag > rest_v) ? rest_v : p + mag;
      if (m_refr != 0 && p == rest_v) m_refr = 0;
    end
    m_pot = p;
  endtask

  task automatic do_slice(input logic [N_IN-1:0] pat, input bit intr);
    int n;
    @(negedge clk);
    spk_i = pat; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0; spk_i = ~pat;  // R2: later input changes must not count
    n = 0;
    while (busy_o) begin
      n++;
      step_i = intr && (n == 2);
      @(negedge clk);
    end
    step_i = 1'b0;
    chk("R2 busy length", n, N_IN + 2);
    model_slice(pat);
    chk("R4 potential", int'(pot_o), m_pot);
    chk("R6 spike", int'(spike_o), m_fire);
    chk("R7 phase", int'(refr_o), m_refr);
    @(negedge clk);
    chk("R11 spike width", int'(spike_o), 0);
    if (intr) chk("R3 no restart", int'(busy_o), 0);
  endtask

  initial begin
    rest_v = 10; thr_v = 100; aft_v = -60; rise = 20; fall = 7;
    wts[0] = 40; wts[1] = -25; wts[2] = 70; wts[3] = 15;
    rest_i = P_W'(rest_v); thr_i = P_W'(thr_v); aft_i = P_W'(aft_v);
    m_pot = 0; m_refr = 0; m_fire = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pot", int'(pot_o), 0);
    chk("R1 reset phase", int'(refr_o), 0);
    chk("R1 reset spike", int'(spike_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    load_mem();

    do_slice('0, 0);  chk("R5 rise toward rest", int'(pot_o), 7);
    do_slice('0, 0);  chk("R5 clamp at rest", int'(pot_o), 10);
    do_slice(4'b0101, 0); chk("R6 fire to after value", int'(pot_o), -60);
    do_slice(4'b1111, 0); chk("R9 attenuated refractory", int'(pot_o), 9);
    do_slice('0, 0);  chk("R7 back to operational", int'(refr_o), 0);
    refr_abs_i = 1'b1;
    do_slice(4'b0101, 1);
    do_slice(4'b1111, 0); chk("R8 absolute ignores", int'(pot_o), -40);
    do_slice('0, 0); do_slice('0, 0); do_slice('0, 0);
    chk("R7 recovered", int'(refr_o), 0);

    for (int i = 0; i < N_IN; i++) wts[i] = -200;
    load_mem();
    do_slice(4'b1111, 0); chk("R10 negative saturation", int'(pot_o), -505);
    do_slice('0, 0);
    wts[0] = 40; wts[1] = -25; wts[2] = 70; wts[3] = 15;
    load_mem();

    for (int mode = 0; mode < 3; mode++) begin
      refr_abs_i = (mode == 1);
      att_sh_i   = (mode == 2) ? 3'd2 : 3'd1;
      for (int rep = 0; rep < 2; rep++)
        for (int p = 0; p < 16; p++) do_slice(N_IN'(p), (p == 9));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule